// File: doc/BRIEF.md
# SPI Master Register and Interrupt Block

This block is the software-facing register file of an SPI master. A simple word bus carries reads and writes. The block keeps the mode word, the transmit and receive data words, four chip-select configuration words, an interrupt mask, an enable bit and four transfer status flags. The shift engine and the DMA engine sit outside the block. They report progress through per-flag set and clear pulses and a receive-load strobe. In return they get the decoded bits-per-transfer value for each chip select and the last transmit word. A single level interrupt is raised while any status bit is also enabled in the mask.

Only the low 14 bits of the bus address select a register, so the register set repeats every 16 KiB. Register reads come back one cycle after the request and are flagged by a read-valid pulse. A small two-state machine runs the read path:
- `RD_IDLE` moves to `RD_RESP` when a read is requested and otherwise stays in `RD_IDLE`.
- `RD_RESP` stays in `RD_RESP` on a back-to-back read and otherwise returns to `RD_IDLE`.
- Read-valid is high only in `RD_RESP`.

Top module: `spi_regblk`

## Requirements
- R1: After reset, the mode, receive-data and mask registers and all four chip-select words read as zero. The status register reads 0x000000F0: flags at bits 4 (receive end), 5 (transmit end), 6 (receive buffer full) and 7 (transmit buffer empty) are set, and the enable bit 16 is clear.
- R2: A write to the control register (offset 0x00) with bit 0 set makes status bit 16 one. A write with bit 1 set makes it zero. When both bits are set in one write, bit 1 wins and the enable bit ends up cleared.
- R3: A write to offset 0x14 ORs the write data into the mask. A write to offset 0x18 clears each mask bit written as one. The mask reads back at offset 0x1C.
- R4: `irq` is high exactly when the bitwise AND of the status register and the mask is nonzero. It reflects register contents as they stand after each clock edge.
- R5: Status flag k (k = 0..3, at status bit 4+k) is set by `flag_set[k]` and cleared by `flag_clr[k]` at the next edge. When both strobes are high in the same cycle, the set wins.
- R6: Chip-select word i is written and read at offset 0x30+4*i. Its bits-per-transfer output, `cs_bpt[5*i +: 5]`, equals 8 plus bits 7:4 of that word.
- R7: A read request produces `rd_valid` high in the following cycle only. `rd_data` in that cycle holds the register contents from before the request edge, so a write in the same cycle is not yet visible.
- R8: Reads of the control (0x00), transmit (0x0C), interrupt-enable (0x14) and interrupt-disable (0x18) offsets, and of any unmapped offset, return zero. Writes to unmapped offsets and to the status offset (0x10) change no register.
- R9: Address bits 31:14 are ignored: any address whose low 14 bits match a register offset reaches that register.
- R10: The mode register (0x04) stores all 32 written bits. A write to 0x0C drives `tx_word`. `rx_load` captures `rx_word` into the receive register, which reads at 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after bus_rd |
| flag_set | input | 4 | Per-flag set strobes from the transfer engine |
| flag_clr | input | 4 | Per-flag clear strobes from the transfer engine |
| rx_load | input | 1 | Load strobe for received data |
| rx_word | input | 32 | Received data word |
| tx_word | output | 32 | Last word written to the transmit register |
| cs_bpt | output | 20 | Bits per transfer for each chip select, 5 bits each |
| irq | output | 1 | Level interrupt |

## Verification
Several pairs of events can land in the same cycle, and the bench provokes each one:
- A set and a clear strobe for the same flag, in which case the set must win.
- A flag strobe and a bus write to the enable or disable register, after which `irq` is judged on the following cycle against the updated status and mask.
- A read of a register together with a write to the same address, where the returned word must be the old contents.

The random phase draws all of these from the seeded generator. Directed steps force each collision at least once, and a bench model of the registers judges every cycle.

// File: rtl/spi_regblk_pkg.sv
package spi_regblk_pkg;

    // register index within the decoded select vector
    localparam int IX_CTRL  = 0;
    localparam int IX_MODE  = 1;
    localparam int IX_RXD   = 2;
    localparam int IX_TXD   = 3;
    localparam int IX_STAT  = 4;
    localparam int IX_IEN   = 5;
    localparam int IX_IDIS  = 6;
    localparam int IX_IMASK = 7;
    localparam int IX_CS0   = 8;

    localparam int CS_BASE_OFF = 'h30;
    localparam int CS_STRIDE   = 4;

    function automatic int reg_offset(input int ix);
        if (ix >= IX_CS0) return CS_BASE_OFF + CS_STRIDE * (ix - IX_CS0);
        return 4 * ix;
    endfunction

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

endpackage

// File: rtl/spi_regblk_dec.sv
module spi_regblk_dec
    import spi_regblk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WIN_W  = 14,
    parameter int NUM_CS = 4,
    localparam int REG_N = IX_CS0 + NUM_CS
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [REG_N-1:0]  sel
);
    logic [WIN_W-1:0] win_off;
    assign win_off = addr[WIN_W-1:0];

    for (genvar g = 0; g < REG_N; g++) begin : g_sel
        assign sel[g] = (win_off == WIN_W'(reg_offset(g)));
    end
endmodule

// File: rtl/spi_regblk_flags.sv
module spi_regblk_flags #(
    parameter int DATA_W    = 32,
    parameter int NUM_FLAGS = 4,
    parameter int FLAG_LSB  = 4,
    parameter int EN_BIT    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] flag_set,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    input  logic                 en_on,
    input  logic                 en_off,
    output logic [DATA_W-1:0]    status
);
    logic [NUM_FLAGS-1:0] flg_q;
    logic                 en_q;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           flg_q[g] <= 1'b1;
            else if (flag_set[g]) flg_q[g] <= 1'b1;
            else if (flag_clr[g]) flg_q[g] <= 1'b0;
        end

        p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            flag_set[g] |=> flg_q[g]);
        p_clr_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr[g] && !flag_set[g]) |=> !flg_q[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (en_off) en_q <= 1'b0;
        else if (en_on)  en_q <= 1'b1;
    end

    always_comb begin
        status = '0;
        status[FLAG_LSB +: NUM_FLAGS] = flg_q;
        status[EN_BIT] = en_q;
    end

    p_en_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_on && !en_off) |=> status[EN_BIT]);
    p_en_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_off |=> !status[EN_BIT]);
endmodule

// File: rtl/spi_regblk_rdport.sv
module spi_regblk_rdport
    import spi_regblk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    rd_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            RD_IDLE: state_d = rd_req ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_req ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= rd_word;
    end

    assign rd_valid = (state_q == RD_RESP);

    p_rd_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    p_rd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
endmodule

// File: rtl/spi_regblk.sv
module spi_regblk
    import spi_regblk_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int WIN_W     = 14,
    parameter int NUM_CS    = 4,
    parameter int NUM_FLAGS = 4,
    parameter int FLAG_LSB  = 4,
    parameter int EN_BIT    = 16,
    parameter int BPT_W     = 5,
    parameter int BPT_BASE  = 8,
    parameter int BPT_LSB   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    rd_valid,
    input  logic [NUM_FLAGS-1:0]    flag_set,
    input  logic [NUM_FLAGS-1:0]    flag_clr,
    input  logic                    rx_load,
    input  logic [DATA_W-1:0]       rx_word,
    output logic [DATA_W-1:0]       tx_word,
    output logic [NUM_CS*BPT_W-1:0] cs_bpt,
    output logic                    irq
);
    localparam int REG_N     = IX_CS0 + NUM_CS;
    localparam int BPT_FLD_W = BPT_W - 1;

    logic [REG_N-1:0]  sel, wr_sel;
    logic [DATA_W-1:0] status, mode_q, rxd_q, txd_q, mask_q, rd_word;
    logic [DATA_W-1:0] csr_q [NUM_CS];

    spi_regblk_dec #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .NUM_CS(NUM_CS)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_sel = bus_wr ? sel : '0;

    spi_regblk_flags #(
        .DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS), .FLAG_LSB(FLAG_LSB), .EN_BIT(EN_BIT)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_set (flag_set),
        .flag_clr (flag_clr),
        .en_on    (wr_sel[IX_CTRL] & bus_wdata[0]),
        .en_off   (wr_sel[IX_CTRL] & bus_wdata[1]),
        .status   (status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            rxd_q  <= '0;
            txd_q  <= '0;
            mask_q <= '0;
        end else begin
            if (wr_sel[IX_MODE]) mode_q <= bus_wdata;
            if (wr_sel[IX_TXD])  txd_q  <= bus_wdata;
            if (rx_load)         rxd_q  <= rx_word;
            if (wr_sel[IX_IEN])       mask_q <= mask_q | bus_wdata;
            else if (wr_sel[IX_IDIS]) mask_q <= mask_q & ~bus_wdata;
        end
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                csr_q[g] <= '0;
            else if (wr_sel[IX_CS0+g]) csr_q[g] <= bus_wdata;
        end
        assign cs_bpt[g*BPT_W +: BPT_W] =
            BPT_W'(BPT_BASE) + BPT_W'(csr_q[g][BPT_LSB +: BPT_FLD_W]);
    end

    always_comb begin
        rd_word = '0;
        if (sel[IX_MODE])  rd_word = mode_q;
        if (sel[IX_RXD])   rd_word = rxd_q;
        if (sel[IX_STAT])  rd_word = status;
        if (sel[IX_IMASK]) rd_word = mask_q;
        for (int i = 0; i < NUM_CS; i++) begin
            if (sel[IX_CS0+i]) rd_word = csr_q[i];
        end
    end

    spi_regblk_rdport #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (bus_rd),
        .rd_word  (rd_word),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign tx_word = txd_q;
    assign irq     = |(status & mask_q);

    p_ien_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[IX_IEN] |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));
    p_idis_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[IX_IDIS] |=> ((mask_q & $past(bus_wdata)) == '0));
    p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_sel[IX_IEN] || wr_sel[IX_IDIS]) |=> $stable(mask_q));
endmodule

// File: tb/tb_spi_regblk.sv
`timescale 1ns/1ps
module tb_spi_regblk;
    localparam int WD_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0, rx_word = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, rx_load = 1'b0;
    logic [3:0]  flag_set = '0, flag_clr = '0;
    logic [31:0] rd_data, tx_word;
    logic        rd_valid, irq;
    logic [19:0] cs_bpt;

    int n_checks = 0;
    int n_fails  = 0;

    // bench model
    logic [31:0] m_mode, m_rxd, m_txd, m_mask, m_stat;
    logic [31:0] m_csr [4];

    always #2 clk = ~clk;

    spi_regblk dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .flag_set(flag_set), .flag_clr(flag_clr),
        .rx_load(rx_load), .rx_word(rx_word), .tx_word(tx_word),
        .cs_bpt(cs_bpt), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [31:0] a);
        logic [13:0] o = a[13:0];
        case (o)
            14'h04: return m_mode;
            14'h08: return m_rxd;
            14'h10: return m_stat;
            14'h1C: return m_mask;
            14'h30: return m_csr[0];
            14'h34: return m_csr[1];
            14'h38: return m_csr[2];
            14'h3C: return m_csr[3];
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_reset();
        m_mode = 0; m_rxd = 0; m_txd = 0; m_mask = 0; m_stat = 32'h0000_00F0;
        for (int i = 0; i < 4; i++) m_csr[i] = 0;
    endtask

    task automatic m_update(input logic [31:0] a, input logic wr, input logic [31:0] d,
                            input logic [3:0] s, input logic [3:0] c,
                            input logic rl, input logic [31:0] rw);
        logic [13:0] o = a[13:0];
        for (int k = 0; k < 4; k++) begin
            if (s[k]) m_stat[4+k] = 1'b1;
            else if (c[k]) m_stat[4+k] = 1'b0;
        end
        if (rl) m_rxd = rw;
        if (wr) begin
            case (o)
                14'h00: begin
                    if (d[0]) m_stat[16] = 1'b1;
                    if (d[1]) m_stat[16] = 1'b0;
                end
                14'h04: m_mode = d;
                14'h0C: m_txd = d;
                14'h14: m_mask = m_mask | d;
                14'h18: m_mask = m_mask & ~d;
                14'h30: m_csr[0] = d;
                14'h34: m_csr[1] = d;
                14'h38: m_csr[2] = d;
                14'h3C: m_csr[3] = d;
                default: ;
            endcase
        end
    endtask

    // one bus cycle; called just after a falling edge
    task automatic step(input logic [31:0] a, input logic wr, input logic rd,
                        input logic [31:0] d, input logic [3:0] s, input logic [3:0] c,
                        input logic rl, input logic [31:0] rw);
        logic [31:0] exp_rd;
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d;
        flag_set = s; flag_clr = c; rx_load = rl; rx_word = rw;
        exp_rd = m_read(a);
        @(posedge clk);
        m_update(a, wr, d, s, c, rl, rw);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; flag_set = 0; flag_clr = 0; rx_load = 0;
        chk("R7 rd_valid", {31'b0, rd_valid}, {31'b0, rd});
        if (rd) chk("R7/R8 rd_data", rd_data, exp_rd);
        chk("R4 irq", {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
        chk("R10 tx_word", tx_word, m_txd);
        for (int i = 0; i < 4; i++)
            chk("R6 cs_bpt", {27'b0, cs_bpt[5*i +: 5]}, 32'(8 + m_csr[i][7:4]));
    endtask

    task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
        step(a, 0, 1, 0, 0, 0, 0, 0);
        chk(req, rd_data, exp);
    endtask

    task automatic idle();
        step(32'h200, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(WD_CYCLES * 4);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd_chk("R1 status reset", 32'h10, 32'h0000_00F0);
        rd_chk("R1 mode reset", 32'h04, 0);
        rd_chk("R1 rxd reset", 32'h08, 0);
        rd_chk("R1 mask reset", 32'h1C, 0);
        for (int i = 0; i < 4; i++) rd_chk("R1 csr reset", 32'h30 + 4*i, 0);

        // R2 enable command
        step(32'h00, 1, 0, 32'h1, 0, 0, 0, 0);
        rd_chk("R2 enable on", 32'h10, 32'h0001_00F0);
        step(32'h00, 1, 0, 32'h3, 0, 0, 0, 0);
        rd_chk("R2 both bits clear", 32'h10, 32'h0000_00F0);
        step(32'h00, 1, 0, 32'h1, 0, 0, 0, 0);
        step(32'h00, 1, 0, 32'h2, 0, 0, 0, 0);
        rd_chk("R2 disable", 32'h10, 32'h0000_00F0);

        // R3 mask set / clear, R4 irq
        step(32'h14, 1, 0, 32'h0001_0010, 0, 0, 0, 0);
        step(32'h14, 1, 0, 32'h0000_0100, 0, 0, 0, 0);
        rd_chk("R3 mask or", 32'h1C, 32'h0001_0110);
        chk("R4 irq with flag masked in", {31'b0, irq}, 1);
        step(32'h18, 1, 0, 32'h0000_0010, 0, 0, 0, 0);
        rd_chk("R3 mask clear", 32'h1C, 32'h0001_0100);
        chk("R4 irq low", {31'b0, irq}, 0);

        // R5 set wins, clear alone, collision with mask write
        step(32'h200, 0, 0, 0, 4'hF, 4'hF, 0, 0);
        rd_chk("R5 set wins", 32'h10, 32'h0000_00F0);
        step(32'h200, 0, 0, 0, 4'h0, 4'h5, 0, 0);
        rd_chk("R5 clear", 32'h10, 32'h0000_00A0);
        step(32'h14, 1, 0, 32'h10, 4'h1, 4'h0, 0, 0);
        chk("R4 strobe and enable same cycle", {31'b0, irq}, 1);

        // R7 read with write to same register in the same cycle
        step(32'h04, 1, 0, 32'hDEAD_BEEF, 0, 0, 0, 0);
        step(32'h04, 1, 1, 32'h1234_5678, 0, 0, 0, 0);
        chk("R7 old value returned", rd_data, 32'hDEAD_BEEF);
        rd_chk("R10 mode full width", 32'h04, 32'h1234_5678);

        // R9 address window alias
        step(32'hABCD_4004, 1, 0, 32'h0F0F_0F0F, 0, 0, 0, 0);
        rd_chk("R9 alias write", 32'h04, 32'h0F0F_0F0F);
        rd_chk("R9 alias read", 32'h8000_C01C, m_mask);

        // R8 zero reads and ignored writes
        step(32'h20, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step(32'h10, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd_chk("R8 status write ignored", 32'h10, m_stat);
        rd_chk("R8 mode kept", 32'h04, 32'h0F0F_0F0F);
        rd_chk("R8 unmapped read", 32'h20, 0);
        rd_chk("R8 ctrl read", 32'h00, 0);
        step(32'h0C, 1, 0, 32'hCAFE_0001, 0, 0, 0, 0);
        rd_chk("R8 txd read", 32'h0C, 0);
        chk("R10 tx_word", tx_word, 32'hCAFE_0001);

        // R6 bits per transfer, R10 receive load
        step(32'h38, 1, 0, 32'h0000_00F0, 0, 0, 0, 0);
        chk("R6 max bpt", {27'b0, cs_bpt[10 +: 5]}, 23);
        step(32'h200, 0, 0, 0, 0, 0, 1, 32'h5A5A_A5A5);
        rd_chk("R10 rx load", 32'h08, 32'h5A5A_A5A5);

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a, d;
            int pick = $urandom % 14;
            if (pick < 8) a = 4 * pick;
            else if (pick < 12) a = 32'h30 + 4 * (pick - 8);
            else if (pick == 12) a = 32'h24;
            else a = $urandom & 32'h0000_3FFC;
            a = a | ($urandom & 32'hFFFF_C000);
            d = $urandom;
            step(a, ($urandom % 2) == 1, ($urandom % 2) == 1, d,
                 4'($urandom & $urandom), 4'($urandom & $urandom),
                 ($urandom % 8) == 0, $urandom);
        end
        rd_chk("R5 final status", 32'h10, m_stat);
        idle();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule